// File: doc/BRIEF.md
# Clock domain source-select divider

This block produces the clock for one clock domain. It picks one of five incoming source clocks through a switch that cannot glitch. It then divides the chosen clock by an integer ratio, or forwards it undivided when bypass is set.

Software controls the block through a single 32-bit configuration word on a simple write/read port clocked by the bus clock. The division ratio is given as two counts. The wait count sets how many source cycles the output stays high, less one. The hold count sets how many source cycles it stays low, less one. The output period is therefore wait + hold + 2 source cycles.

New counts do not act when they are written. They take effect only when an update request bit is set, and only at the end of a whole output period. Both the update and a change of source report a busy flag that software polls. A parameter can pin the domain to one fixed source. Writes to the select field then have no effect.

Top module: `clk_domain_gen`

## Requirements
- R1: After reset the configuration word reads 0. This means source 0, wait = hold = 0, bypass off and both busy flags clear. The output then runs at source 0 divided by 2.
- R2: Outside bypass the output stays high for wait+1 cycles and low for hold+1 cycles of the selected source. Its period is therefore wait+hold+2 source cycles. The wait count sits in bits [19:16] and the hold count in bits [23:20].
- R3: Counts written with bit 25 at 0 are stored and read back, but leave the output unchanged. Writing bit 25 as 1 makes bit 25 read 1 until the stored counts drive the output, after which it clears by itself. Writes to the count fields are ignored while bit 25 reads 1.
- R4: Bits [2:0] select the source: code k (0 to 4) selects src_clk[k]. A write of code 5, 6 or 7 leaves the stored code and the output unchanged.
- R5: After a write that changes the source code, bit 3 reads 1. It returns to 0 once the old source is gated off and the new source drives the output. A write of the current code leaves bit 3 at 0. At no time is more than one source enabled.
- R6: With bit 24 set, the output is the selected source undivided. Clearing bit 24 returns the output to the divided clock.
- R7: The ratio split works at both extremes. For a ratio R, wait = R/2 - 1 (rounded down) and hold = R - wait - 2. R = 32 (wait 15, hold 15) gives a symmetric output. R = 5 (wait 1, hold 2) gives an output that is low for one source cycle longer than it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock for the configuration port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Current configuration and status word |
| src_clk | input | 5 | Candidate source clocks, index = select code |
| clk_out | output | 1 | Domain clock output |

## Verification
The bench measures the high and low durations of the output against five source clocks whose periods are all different. This shows both that the right source drives the output and that the right counts are in use. Count writes without the update bit are separated from requested updates by measuring the output before and after the request. A further count write issued while the update is still busy shows that it is dropped. An asymmetric split (ratio 5) and the widest split (ratio 32) are used to tell a swapped wait/hold pair from a correct one. Bypass is applied on two different sources. Illegal select codes and rewrites of the current code are applied to show that neither one disturbs the output or raises the busy flag.

// File: rtl/cdg_pkg.sv
package cdg_pkg;
  localparam int NUM_SRC    = 5;
  localparam int SEL_W      = 3;
  localparam int F_SEL_LSB  = 0;
  localparam int F_SWBUSY   = 3;
  localparam int F_WAIT_LSB = 16;
  localparam int F_HOLD_LSB = 20;
  localparam int F_BYPASS   = 24;
  localparam int F_UPDATE   = 25;
  localparam int FIELD_MAX  = 4;

  // Output period in source cycles for a wait/hold pair.
  function automatic int unsigned period_of(int unsigned w, int unsigned h);
    return w + h + 2;
  endfunction

  // Split of a ratio into wait and hold counts.
  function automatic int unsigned wait_of(int unsigned r);
    return r / 2 - 1;
  endfunction

  function automatic int unsigned hold_of(int unsigned r);
    return r - wait_of(r) - 2;
  endfunction

  function automatic logic sel_legal(logic [SEL_W-1:0] s);
    return int'(s) < NUM_SRC;
  endfunction
endpackage

// File: rtl/cdg_sync.sv
module cdg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cdg_cfg_regs.sv
module cdg_cfg_regs
  import cdg_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter bit SEL_LOCKED = 1'b0,
  parameter int LOCK_SRC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             sw_busy,
  input  logic             upd_ack_seen,
  output logic [31:0]      rd_data,
  output logic [SEL_W-1:0] sel_q,
  output logic [CNT_W-1:0] cnt_wait,
  output logic [CNT_W-1:0] cnt_hold,
  output logic             bypass_q,
  output logic             upd_req_tgl,
  output logic             upd_busy
);
  localparam logic [SEL_W-1:0] RST_SEL = SEL_LOCKED ? SEL_W'(LOCK_SRC) : '0;

  logic unused_wr;
  assign unused_wr = ^wr_data;

  assign upd_busy = upd_req_tgl ^ upd_ack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= RST_SEL;
      cnt_wait    <= '0;
      cnt_hold    <= '0;
      bypass_q    <= 1'b0;
      upd_req_tgl <= 1'b0;
    end else if (wr_en) begin
      if (!SEL_LOCKED && sel_legal(wr_data[F_SEL_LSB +: SEL_W]))
        sel_q <= wr_data[F_SEL_LSB +: SEL_W];
      bypass_q <= wr_data[F_BYPASS];
      if (!upd_busy) begin
        cnt_wait <= wr_data[F_WAIT_LSB +: CNT_W];
        cnt_hold <= wr_data[F_HOLD_LSB +: CNT_W];
        if (wr_data[F_UPDATE])
          upd_req_tgl <= ~upd_req_tgl;
      end
    end
  end

  always_comb begin
    rd_data                          = '0;
    rd_data[F_SEL_LSB +: SEL_W]      = sel_q;
    rd_data[F_SWBUSY]                = sw_busy;
    rd_data[F_WAIT_LSB +: CNT_W]     = cnt_wait;
    rd_data[F_HOLD_LSB +: CNT_W]     = cnt_hold;
    rd_data[F_BYPASS]                = bypass_q;
    rd_data[F_UPDATE]                = upd_busy;
  end
endmodule

// File: rtl/cdg_src_switch.sv
module cdg_src_switch
  import cdg_pkg::*;
#(
  parameter int NSRC    = 5,
  parameter int RST_SRC = 0
) (
  input  logic             pclk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_clk,
  input  logic [SEL_W-1:0] sel_q,
  output logic [NSRC-1:0]  src_en,
  output logic             clk_mux,
  output logic             sw_busy
);
  localparam logic [NSRC-1:0] RST_OH = NSRC'(1) << RST_SRC;

  logic [NSRC-1:0] sel_oh;
  logic [NSRC-1:0] want;
  logic [NSRC-1:0] armed;
  logic [NSRC-1:0] en_seen;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      sel_oh[i] = (int'(sel_q) == i);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_branch
    localparam logic [NSRC-1:0] OTHERS = ~(NSRC'(1) << g);
    localparam logic            RST_B  = (g == RST_SRC);
    logic arm_b;
    logic en_b;

    // Enable request for this branch: selected and every other branch off.
    assign want[g] = sel_oh[g] & ~|(src_en & OTHERS);

    cdg_sync #(.W(1), .RST_VAL(RST_B)) u_arm_sync (
      .clk   (src_clk[g]),
      .rst_n (rst_n),
      .d     (want[g]),
      .q     (arm_b)
    );

    // Enable changes on the falling edge so the gated clock never chops a high phase.
    always_ff @(negedge src_clk[g] or negedge rst_n) begin
      if (!rst_n) en_b <= RST_B;
      else        en_b <= arm_b;
    end

    assign armed[g]  = arm_b;
    assign src_en[g] = en_b;
  end

  assign clk_mux = |(src_clk & src_en);

  cdg_sync #(.W(NSRC), .RST_VAL(RST_OH)) u_en_sync (
    .clk   (pclk),
    .rst_n (rst_n),
    .d     (src_en),
    .q     (en_seen)
  );

  logic unused_armed;
  assign unused_armed = ^armed;

  assign sw_busy = (en_seen != sel_oh);
endmodule

// File: rtl/cdg_divider.sv
module cdg_divider #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_wait,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic             upd_req_tgl,
  output logic             div_out,
  output logic             upd_ack_tgl,
  output logic             load_evt
);
  logic             req_seen;
  logic             phase_hi;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_wait;
  logic [CNT_W-1:0] cur_hold;
  logic             pending;
  logic             period_end;

  cdg_sync #(.W(1), .RST_VAL(1'b0)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (upd_req_tgl),
    .q     (req_seen)
  );

  assign pending    = req_seen ^ upd_ack_tgl;
  assign period_end = !phase_hi && (cnt == cur_hold);
  assign load_evt   = period_end && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_hi    <= 1'b1;
      cnt         <= '0;
      cur_wait    <= '0;
      cur_hold    <= '0;
      upd_ack_tgl <= 1'b0;
    end else if (phase_hi) begin
      if (cnt == cur_wait) begin
        phase_hi <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else if (period_end) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
      if (pending) begin
        cur_wait    <= cfg_wait;
        cur_hold    <= cfg_hold;
        upd_ack_tgl <= ~upd_ack_tgl;
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign div_out = phase_hi;
endmodule

// File: rtl/clk_domain_gen.sv
module clk_domain_gen
  import cdg_pkg::*;
#(
  parameter int NUM_SRC    = cdg_pkg::NUM_SRC,
  parameter int CNT_W      = 4,
  parameter bit SEL_LOCKED = 1'b0,
  parameter int LOCK_SRC   = 2
) (
  input  logic               pclk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_clk,
  output logic               clk_out
);
  localparam int RST_SRC = SEL_LOCKED ? LOCK_SRC : 0;

  logic [SEL_W-1:0]   sel_q;
  logic [CNT_W-1:0]   cnt_wait;
  logic [CNT_W-1:0]   cnt_hold;
  logic               bypass_q;
  logic               upd_req_tgl;
  logic               upd_busy;
  logic               upd_ack_tgl;
  logic               upd_ack_seen;
  logic               sw_busy;
  logic [NUM_SRC-1:0] src_en;
  logic               clk_mux;
  logic               div_out;
  logic               load_evt;

  cdg_cfg_regs #(.CNT_W(CNT_W), .SEL_LOCKED(SEL_LOCKED), .LOCK_SRC(LOCK_SRC)) u_regs (
    .clk          (pclk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .sw_busy      (sw_busy),
    .upd_ack_seen (upd_ack_seen),
    .rd_data      (rd_data),
    .sel_q        (sel_q),
    .cnt_wait     (cnt_wait),
    .cnt_hold     (cnt_hold),
    .bypass_q     (bypass_q),
    .upd_req_tgl  (upd_req_tgl),
    .upd_busy     (upd_busy)
  );

  cdg_src_switch #(.NSRC(NUM_SRC), .RST_SRC(RST_SRC)) u_switch (
    .pclk    (pclk),
    .rst_n   (rst_n),
    .src_clk (src_clk),
    .sel_q   (sel_q),
    .src_en  (src_en),
    .clk_mux (clk_mux),
    .sw_busy (sw_busy)
  );

  cdg_divider #(.CNT_W(CNT_W)) u_div (
    .clk         (clk_mux),
    .rst_n       (rst_n),
    .cfg_wait    (cnt_wait),
    .cfg_hold    (cnt_hold),
    .upd_req_tgl (upd_req_tgl),
    .div_out     (div_out),
    .upd_ack_tgl (upd_ack_tgl),
    .load_evt    (load_evt)
  );

  cdg_sync #(.W(1), .RST_VAL(1'b0)) u_ack_sync (
    .clk   (pclk),
    .rst_n (rst_n),
    .d     (upd_ack_tgl),
    .q     (upd_ack_seen)
  );

  logic unused_busy;
  assign unused_busy = upd_busy;

  assign clk_out = bypass_q ? clk_mux : div_out;
endmodule

// File: rtl/clk_domain_gen_chk.sv
module clk_domain_gen_chk #(
  parameter int NUM_SRC    = 5,
  parameter bit SEL_LOCKED = 1'b0
) (
  input logic               pclk,
  input logic               rst_n,
  input logic               clk_mux,
  input logic               wr_en,
  input logic [31:0]        wr_data,
  input logic [31:0]        rd_data,
  input logic [NUM_SRC-1:0] src_en,
  input logic               div_out,
  input logic               load_evt
);
  AST_SRC_ONEHOT: assert property (@(posedge pclk) disable iff (!rst_n)
    $onehot0(src_en)); // R5

  AST_SEL_LEGAL: assert property (@(posedge pclk) disable iff (!rst_n)
    int'(rd_data[2:0]) < NUM_SRC); // R4

  AST_ILLEGAL_KEEP: assert property (@(posedge pclk) disable iff (!rst_n)
    (wr_en && int'(wr_data[2:0]) >= NUM_SRC) |=> (rd_data[2:0] == $past(rd_data[2:0]))); // R4

  AST_SWITCH_BUSY: assert property (@(posedge pclk) disable iff (!rst_n)
    (!SEL_LOCKED && wr_en && !rd_data[3] && int'(wr_data[2:0]) < NUM_SRC
     && wr_data[2:0] != rd_data[2:0]) |=> rd_data[3]); // R5

  AST_SWBUSY_FROM_WRITE: assert property (@(posedge pclk) disable iff (!rst_n)
    $rose(rd_data[3]) |-> $past(wr_en)); // R5

  AST_UPD_FROM_WRITE: assert property (@(posedge pclk) disable iff (!rst_n)
    $rose(rd_data[25]) |-> $past(wr_en && wr_data[25])); // R3

  AST_LOAD_STARTS_HIGH: assert property (@(posedge clk_mux) disable iff (!rst_n)
    load_evt |=> div_out); // R2
endmodule

bind clk_domain_gen clk_domain_gen_chk #(.NUM_SRC(NUM_SRC), .SEL_LOCKED(SEL_LOCKED)) u_chk (
  .pclk     (pclk),
  .rst_n    (rst_n),
  .clk_mux  (clk_mux),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .src_en   (src_en),
  .div_out  (div_out),
  .load_evt (load_evt)
);

// File: tb/clk_domain_gen_test.sv
`timescale 1ns/1ps
module clk_domain_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF [5] = '{7, 11, 3, 5, 13};

  logic        pclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [4:0]  src_clk;
  logic        clk_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    int    hi;
    int    lo;
    string req;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // Bench-side configuration model.
  int cur_src = 0, cur_w = 0, cur_h = 0;
  bit cur_byp = 0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  for (genvar k = 0; k < 5; k++) begin : g_src
    logic ck = 1'b0;
    initial forever #(HALF[k]) ck = ~ck;
    assign src_clk[k] = ck;
  end

  clk_domain_gen uut (
    .pclk    (pclk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .src_clk (src_clk),
    .clk_out (clk_out)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] word(int sel, int w, int h, bit byp, bit upd);
    return 32'(sel) | (32'(w) << 16) | (32'(h) << 20) | (32'(byp) << 24) | (32'(upd) << 25);
  endfunction

  task automatic wr(logic [31:0] d);
    @(negedge pclk);
    wr_en = 1'b1; wr_data = d;
    @(negedge pclk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic poll_clear(int bitpos, string req);
    int n = 0;
    while (rd_data[bitpos] && n < 5000) begin
      @(negedge pclk);
      n++;
    end
    check(!rd_data[bitpos], req, $sformatf("busy bit %0d clears", bitpos), rd_data[bitpos], 0);
  endtask

  // Driver side of the scoreboard: queue the expected output shape, wait until compared.
  task automatic expect_period(string req, string tag);
    exp_t e;
    int p = 2 * HALF[cur_src];
    if (cur_byp) begin
      e.hi = HALF[cur_src];
      e.lo = HALF[cur_src];
    end else begin
      e.hi = (cur_w + 1) * p;
      e.lo = (cur_h + 1) * p;
    end
    e.req = req; e.tag = tag;
    exp_q.push_back(e);
    while (exp_q.size() != 0) @(negedge pclk);
  endtask

  // Monitor side: measure one whole output period per queued item.
  initial begin
    forever begin
      exp_t e;
      longint t0, t1, t2;
      while (exp_q.size() == 0) @(negedge pclk);
      e = exp_q[0];
      @(posedge clk_out);
      @(posedge clk_out);
      t0 = $time;
      @(negedge clk_out);
      t1 = $time;
      @(posedge clk_out);
      t2 = $time;
      check((t1 - t0) == e.hi, e.req, {e.tag, " high ns"}, t1 - t0, e.hi);
      check((t2 - t1) == e.lo, e.req, {e.tag, " low ns"}, t2 - t1, e.lo);
      void'(exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  // Ratio split restated: hold takes the upper half minus one.
  function automatic int hold_for(int r);
    return (r + 1) / 2 - 1;
  endfunction

  initial begin
    int h5, w5;
    repeat (4) @(negedge pclk);
    rst_n = 1'b1;
    @(negedge pclk);

    // R1: reset state and default divide-by-2 of source 0
    check(rd_data == 32'h0, "R1", "reset word", rd_data, 0);
    expect_period("R1", "reset src0 div2");

    // R3: counts without request are stored but do not act
    wr(word(0, 3, 1, 0, 0));
    check(rd_data[19:16] == 4'd3 && rd_data[23:20] == 4'd1, "R3", "stored counts",
          rd_data[23:16], 8'h13);
    check(rd_data[25] == 1'b0, "R3", "no update busy", rd_data[25], 0);
    expect_period("R3", "counts not applied");

    // R3/R2: request applies counts
    wr(word(0, 3, 1, 0, 1));
    check(rd_data[25] == 1'b1, "R3", "update busy after request", rd_data[25], 1);
    poll_clear(25, "R3");
    cur_w = 3; cur_h = 1;
    expect_period("R2", "w3 h1 on src0");

    // R5: switch to source 2
    wr(word(2, 3, 1, 0, 0));
    check(rd_data[3] == 1'b1, "R5", "switch busy after change", rd_data[3], 1);
    poll_clear(3, "R5");
    cur_src = 2;
    check(rd_data[2:0] == 3'd2, "R4", "select code 2", rd_data[2:0], 2);
    expect_period("R4", "src2 w3 h1");

    // R5: same code does not raise busy
    wr(word(2, 3, 1, 0, 0));
    check(rd_data[3] == 1'b0, "R5", "no busy on same code", rd_data[3], 0);

    // R4: illegal code ignored
    wr(word(6, 3, 1, 0, 0));
    check(rd_data[2:0] == 3'd2, "R4", "illegal code kept old", rd_data[2:0], 2);
    check(rd_data[3] == 1'b0, "R4", "illegal code no busy", rd_data[3], 0);
    expect_period("R4", "after illegal code");

    // R7: widest ratio 32
    cur_h = hold_for(32); cur_w = 32 - cur_h - 2;
    wr(word(2, cur_w, cur_h, 0, 1));
    poll_clear(25, "R7");
    expect_period("R7", "ratio 32");

    // R7 + R3: ratio 5, then a count write during busy is dropped
    h5 = hold_for(5); w5 = 5 - h5 - 2;
    wr(word(2, w5, h5, 0, 1));
    wr(word(2, 9, 9, 0, 0));
    check(rd_data[19:16] == 4'(w5) && rd_data[23:20] == 4'(h5), "R3",
          "count write during busy ignored", rd_data[23:16], (h5 << 4) | w5);
    poll_clear(25, "R3");
    cur_w = w5; cur_h = h5;
    expect_period("R7", "ratio 5");

    // R6: bypass on source 2
    wr(word(2, w5, h5, 1, 0));
    cur_byp = 1;
    check(rd_data[24] == 1'b1, "R6", "bypass bit", rd_data[24], 1);
    expect_period("R6", "bypass src2");

    // R5/R6: switch to source 4 in bypass
    wr(word(4, w5, h5, 1, 0));
    poll_clear(3, "R5");
    cur_src = 4;
    expect_period("R6", "bypass src4");

    // R6: bypass off returns to divider
    wr(word(4, w5, h5, 0, 0));
    cur_byp = 0;
    expect_period("R6", "divided src4");

    // R4: other legal codes
    for (int s = 1; s <= 3; s += 2) begin
      wr(word(s, w5, h5, 0, 0));
      poll_clear(3, "R5");
      cur_src = s;
      check(int'(rd_data[2:0]) == s, "R4", "select readback", rd_data[2:0], s);
      expect_period("R4", $sformatf("src%0d ratio 5", s));
    end

    done = 1;
    finish_run();
  end
endmodule